// File: doc/BRIEF.md
# Two-Dimensional Parity Corrector

This block repairs the sixteen protected bits of an aligned frame (a 7-bit character, a 5-bit station address and a 4-bit frame number) using nine received parity bits. The protected bits are laid out as a 4×4 grid. Eight parity bits give odd parity over the four rows and the four columns. A ninth bit gives even parity over those eight.

When a frame is presented with a one-cycle strobe, the block computes the row and column syndromes. It inverts the single protected bit that both a failing row and a failing column point at. It also recognises a lone failure among the parity bits themselves. Every other mismatch is reported as uncorrectable. An optional spare frame bit can be checked as the inverse of the ninth parity bit.

The results are registered and appear one clock after the strobe. A frame receiver feeds the block, and a character formatter reads its output.

Top module: `parity2d_fix`

## Requirements
- R1: The grid has bit index k = 4*row + col. It is filled from {in_num, in_addr, in_data}: in_data[6:0] takes k = 0..6, in_addr[4:0] takes k = 7..11, and in_num[3:0] takes k = 12..15. in_par[r] (r = 0..3) equals the XOR of row r XOR 1. in_par[4+c] (c = 0..3) equals the XOR of column c XOR 1. in_par[8] equals the XOR of in_par[7:0]. A frame that obeys all of this comes out unchanged, with out_corrected = 0 and out_error = 0.
- R2: A frame with exactly one protected bit inverted comes out with that bit restored, out_corrected = 1 and out_error = 0.
- R3: A frame with exactly one of in_par[7:0] inverted comes out with the protected bits unchanged, out_corrected = 1 and out_error = 0.
- R4: A frame with only in_par[8] inverted comes out with the protected bits unchanged, out_corrected = 1 and out_error = 0.
- R5: A frame with two protected bits inverted gives out_error = 1 and out_corrected = 0. Its protected bits are passed through exactly as received.
- R6: When spare_chk_en = 1 and in_spare equals in_par[8], the result has out_error = 1 and out_corrected = 0, and the received bits are passed through. When spare_chk_en = 0, in_spare has no effect on any output.
- R7: out_valid is 1 in exactly the cycle after each cycle in which in_valid = 1. out_corrected and out_error are 0 whenever out_valid = 0.
- R8: While in_valid = 0, out_data, out_addr and out_num hold their last values.
- R9: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Frame strobe |
| in_data | input | 7 | Received character bits |
| in_addr | input | 5 | Received station address |
| in_num | input | 4 | Received frame number |
| in_par | input | 9 | Received parity bits, row parities in [3:0], column parities in [7:4], overall parity in [8] |
| in_spare | input | 1 | Spare frame bit |
| spare_chk_en | input | 1 | Enables the check of in_spare against the inverse of in_par[8] |
| out_data | output | 7 | Corrected character |
| out_addr | output | 5 | Corrected address |
| out_num | output | 4 | Corrected frame number |
| out_corrected | output | 1 | A single error was repaired |
| out_error | output | 1 | The errors could not be repaired |
| out_valid | output | 1 | Result strobe |

## Verification
The assertions assume that the frame fields are sampled only in strobe cycles. They also assume the spare check depends only on the received ninth parity bit and never on a corrected value. The bench drives fields only together with in_valid, or while the strobe is low to check the hold behaviour. Its error patterns are limited to cases whose outcome is unambiguous: one inverted bit, two inverted protected bits, or a spare mismatch. It never combines a protected-bit error with a parity-bit error, because such a pair is indistinguishable from a single parity fault.

// File: rtl/parity2d_fix.sv
module parity2d_fix (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [6:0] in_data,
  input  logic [4:0] in_addr,
  input  logic [3:0] in_num,
  input  logic [8:0] in_par,
  input  logic       in_spare,
  input  logic       spare_chk_en,
  output logic [6:0] out_data,
  output logic [4:0] out_addr,
  output logic [3:0] out_num,
  output logic       out_corrected,
  output logic       out_error,
  output logic       out_valid
);
  localparam int N = 4;

  logic [N*N-1:0] grid, mask, fixed;
  logic [N-1:0]   row_bad, col_bad;
  logic           all_bad, row_one, col_one, row_none, col_none;
  logic           bit_err, par_err, clean, spare_bad;

  assign grid = {in_num, in_addr, in_data};

  for (genvar r = 0; r < N; r++) begin : g_row
    assign row_bad[r] = in_par[r] ^ (^grid[N*r +: N]) ^ 1'b1;
  end

  for (genvar c = 0; c < N; c++) begin : g_col
    logic [N-1:0] col;
    for (genvar r = 0; r < N; r++) begin : g_bit
      assign col[r] = grid[N*r + c];
      assign mask[N*r + c] = row_bad[r] & col_bad[c];
    end
    assign col_bad[c] = in_par[N + c] ^ (^col) ^ 1'b1;
  end

  assign all_bad  = ^in_par;
  assign row_one  = $onehot(row_bad);
  assign col_one  = $onehot(col_bad);
  assign row_none = ~|row_bad;
  assign col_none = ~|col_bad;

  assign bit_err   = row_one & col_one & ~all_bad;
  assign par_err   = all_bad & ((row_one & col_none) | (row_none & col_one) | (row_none & col_none));
  assign clean     = row_none & col_none & ~all_bad;
  assign spare_bad = spare_chk_en & (in_spare == in_par[8]);

  assign fixed = (bit_err && !spare_bad) ? (grid ^ mask) : grid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data      <= '0;
      out_addr      <= '0;
      out_num       <= '0;
      out_corrected <= 1'b0;
      out_error     <= 1'b0;
      out_valid     <= 1'b0;
    end else begin
      out_valid     <= in_valid;
      out_corrected <= in_valid & (bit_err | par_err) & ~spare_bad;
      out_error     <= in_valid & (spare_bad | ~(clean | bit_err | par_err));
      if (in_valid) {out_num, out_addr, out_data} <= fixed;
    end
  end
endmodule

module parity2d_fix_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [6:0] in_data,
  input logic [4:0] in_addr,
  input logic [3:0] in_num,
  input logic [8:0] in_par,
  input logic       in_spare,
  input logic       spare_chk_en,
  input logic [6:0] out_data,
  input logic [4:0] out_addr,
  input logic [3:0] out_num,
  input logic       out_corrected,
  input logic       out_error,
  input logic       out_valid
);
  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R7
  flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_corrected && !out_error);
  // R5
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_corrected && out_error));
  // R5
  raw_on_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> !out_error || {out_num, out_addr, out_data} == $past({in_num, in_addr, in_data}));
  // R6
  spare_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && spare_chk_en && (in_spare == in_par[8]) |=> out_error);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable({out_num, out_addr, out_data}));
endmodule

bind parity2d_fix parity2d_fix_chk u_chk (.*);

// File: tb/parity2d_fix_test.sv
module parity2d_fix_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_spare = 1'b0, spare_chk_en = 1'b0;
  logic [6:0] in_data = '0;
  logic [4:0] in_addr = '0;
  logic [3:0] in_num = '0;
  logic [8:0] in_par = '0;
  logic [6:0] out_data;
  logic [4:0] out_addr;
  logic [3:0] out_num;
  logic out_corrected, out_error, out_valid;

  typedef struct packed {
    logic [15:0] bits;
    logic        corr;
    logic        err;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  logic [15:0] last_bits;

  always #(PERIOD/2) clk = ~clk;

  parity2d_fix uut (.*);

  function automatic logic [8:0] enc(input logic [15:0] k);
    logic [8:0] p;
    for (int r = 0; r < 4; r++) p[r] = ~(k[4*r] ^ k[4*r+1] ^ k[4*r+2] ^ k[4*r+3]);
    for (int c = 0; c < 4; c++) p[4+c] = ~(k[c] ^ k[c+4] ^ k[c+8] ^ k[c+12]);
    p[8] = ^p[7:0];
    return p;
  endfunction

  task automatic check(input string req, input logic [17:0] got, input logic [17:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send(input logic [15:0] k, input logic [24:0] flip,
                      input logic sen, input logic sbad, input logic ec, input logic ee);
    logic [24:0] fr;
    exp_t e;
    fr = {enc(k), k} ^ flip;
    in_valid = 1'b1;
    {in_par, in_num, in_addr, in_data} = fr;
    spare_chk_en = sen;
    in_spare = ~fr[24] ^ sbad;
    e.bits = ee ? fr[15:0] : k;
    e.corr = ec;
    e.err = ee;
    q.push_back(e);
    last_bits = e.bits;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) check("R7", 18'h1, 18'h0);
      else begin
        exp_t e;
        e = q.pop_front();
        // R1 R2 R3 R4 R5 R6
        check("R1-data", {2'b0, out_num, out_addr, out_data}, {2'b0, e.bits});
        check("R2-flags", {16'b0, out_corrected, out_error}, {16'b0, e.corr, e.err});
      end
    end
  end

  initial begin
    #(PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9
    check("R9", {out_num, out_addr, out_data, out_corrected, out_error, out_valid}, 18'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 clean frames
    send(16'h0000, 25'h0, 0, 0, 0, 0);
    send(16'hFFFF, 25'h0, 0, 0, 0, 0);
    send(16'hA5C3, 25'h0, 0, 0, 0, 0);
    idle(1);
    send(16'h1234, 25'h0, 0, 0, 0, 0);
    idle(2);

    // R2 every protected bit
    for (int i = 0; i < 16; i++) send(16'h5A3C ^ 16'(i * 16'h0911), 25'(1) << i, 0, 0, 1, 0);
    idle(1);
    // R3 each row/column parity bit
    for (int i = 16; i < 24; i++) send(16'hC0DE, 25'(1) << i, 0, 0, 1, 0);
    // R4 overall parity bit
    send(16'h7E81, 25'(1) << 24, 0, 0, 1, 0);
    idle(1);

    // R5 double errors: same row, same column, diagonal
    send(16'h3333, 25'h00003, 0, 0, 0, 1);
    send(16'h9999, 25'h01001, 0, 0, 0, 1);
    send(16'hBEEF, 25'h00021, 0, 0, 0, 1);
    idle(1);

    // R6 spare check
    send(16'h4321, 25'h0, 1, 1, 0, 1);
    send(16'h4321, 25'h0, 1, 0, 0, 0);
    send(16'h4321, 25'h0, 0, 1, 0, 0);
    send(16'h0F0F, 25'h00010, 1, 1, 0, 1);
    send(16'h0F0F, 25'h00010, 0, 1, 1, 0);

    // R8 hold while idle, then R7 flags quiet
    in_valid = 1'b0;
    in_data = 7'h55; in_addr = 5'h0A; in_num = 4'h9; in_par = 9'h1FF;
    repeat (3) @(negedge clk);
    check("R8", {2'b0, out_num, out_addr, out_data}, {2'b0, last_bits});
    check("R7", {15'b0, out_valid, out_corrected, out_error}, 18'h0);
    check("R7-queue", 18'(q.size()), 18'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule